// File: doc/BRIEF.md
# Dual Lookup-Table Logic Cell

This block is one configurable logic cell of a programmable fabric. It holds two small truth tables in writable storage, each addressed by a group of function inputs. Used as two halves, the cell computes two unrelated functions of up to four inputs each. Used whole, both tables see the same four inputs and a fifth input picks which table answers. Any function of five inputs therefore fits in one cell, however irregular its truth table.

Each of the two outputs is either combinational or taken from a flip-flop. The flip-flop loads only while the clock enable is high and clears on a synchronous reset. A single parallel write port loads either table, or the mode word, in one clock edge. The table width and the per-table input count follow from one parameter.

Top module: `clb_cell`

## Requirements
- R1: With merging off (mode bit 0 clear), `out_f` equals bit `in_f` of table F and `out_g` equals bit `in_g` of table G. The input vector is the bit index, with input bit 0 as its least significant bit.
- R2: On a rising edge with `cfg_we` high, `cfg_data` is loaded into the target named by `cfg_tgt`: 0 selects table F, 1 selects table G, 2 selects the mode word, and 3 selects nothing. The new contents act from the next cycle on.
- R3: With merging on (mode bit 0 set), both tables are addressed by `in_f`. `out_f` equals table F's bit when `in_5` is 0 and table G's bit when `in_5` is 1.
- R4: With merging on, `out_g` equals bit `in_f` of table G.
- R5: Mode bit 1 (for `out_f`) and mode bit 2 (for `out_g`) select the registered path. The output then shows the function value captured at the last rising edge on which `clk_en` was high.
- R6: A rising edge with `clk_en` low leaves a registered output unchanged, even when the inputs change.
- R7: A rising edge with `rst` high clears both output registers, both tables and the mode word to 0.
- R8: With a register bit clear, the matching output follows input changes within the same cycle.
- R9: With a fixed set of table contents, the cell in split mode produces A==B on `out_f` and A>B on `out_g` for two 2-bit operands A and B. Each operand is given as {A, B}, with A in bits 3:2, on both input groups.
- R10: With a fixed set of table contents, the cell in merged mode produces the majority of its five inputs `in_5` and `in_f[3:0]`.
- R11: A rising edge with `cfg_we` low changes neither table nor the mode word, whatever `cfg_tgt` and `cfg_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Load enable for the output registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 2 | Write target: 0 table F, 1 table G, 2 mode word, 3 none |
| cfg_data | input | 2**K | Table contents, or mode word in bits 2:0 |
| in_f | input | K | Address for table F, and the shared address when merged |
| in_g | input | K | Address for table G in split mode |
| in_5 | input | 1 | Table select when merged |
| out_f | output | 1 | First function output |
| out_g | output | 1 | Second function output |

## Verification
The bench builds the cell with its default of four inputs per table, so each table has 16 bits. At that size every pair of input groups (256 combinations) can be swept in split mode, and all 32 five-input patterns can be swept in merged mode. Expected values come from the written table words, and from comparison and population-count arithmetic for the comparator and the majority function. Both output paths are tested in a mode where one output is registered and the other is not, so capture, hold and bypass are all seen in the same cycles.

// File: rtl/clb_pkg.sv
package clb_pkg;

    typedef enum logic [1:0] {
        TGT_LUT_F = 2'd0,
        TGT_LUT_G = 2'd1,
        TGT_MODE  = 2'd2,
        TGT_NONE  = 2'd3
    } cfg_tgt_e;

    // bit 0 merge, bit 1 register out_f, bit 2 register out_g
    typedef struct packed {
        logic reg_g;
        logic reg_f;
        logic merge;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [(1<<K)-1:0]   wr_data,
    input  logic [K-1:0]        sel,
    output logic                dout
);
    localparam int TBL = 1 << K;

    typedef struct packed {
        logic [TBL-1:0] bits;
    } lut_state_t;

    lut_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (wr_en) begin
            st_d.bits = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.bits[sel];

endmodule

// File: rtl/clb_merge.sv
module clb_merge #(
    parameter int K = 4
) (
    input  logic         merge,
    input  logic         in_5,
    input  logic [K-1:0] in_f,
    input  logic [K-1:0] in_g,
    input  logic         lut_f,
    input  logic         lut_g,
    output logic [K-1:0] sel_f,
    output logic [K-1:0] sel_g,
    output logic         comb_f,
    output logic         comb_g
);
    always_comb begin
        sel_f  = in_f;
        sel_g  = merge ? in_f : in_g;
        comb_f = (merge && in_5) ? lut_g : lut_f;
        comb_g = lut_g;
    end

endmodule

// File: rtl/clb_outreg.sv
module clb_outreg (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic use_reg,
    input  logic d,
    output logic q,
    output logic y
);
    typedef struct packed {
        logic val;
    } oreg_t;

    oreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = 1'b0;
        end else if (ce) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;
    assign y = use_reg ? st_q.val : d;

endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
#(
    parameter int K = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_tgt,
    input  logic [(1<<K)-1:0]   cfg_data,
    input  logic [K-1:0]        in_f,
    input  logic [K-1:0]        in_g,
    input  logic                in_5,
    output logic                out_f,
    output logic                out_g
);
    localparam int TBL = 1 << K;
    localparam int NLUT = 2;

    mode_t          mode_d, mode_q;
    logic [K-1:0]   lut_sel [NLUT];
    logic           lut_val [NLUT];
    logic           lut_wr  [NLUT];
    logic           comb    [NLUT];
    logic           oq      [NLUT];
    logic           oy      [NLUT];
    logic           oreg_on [NLUT];
    cfg_tgt_e       tgt;

    assign tgt = cfg_tgt_e'(cfg_tgt);

    always_comb begin
        mode_d = mode_q;
        if (rst) begin
            mode_d = '0;
        end else if (cfg_we && tgt == TGT_MODE) begin
            mode_d = mode_t'(cfg_data[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign lut_wr[0]  = cfg_we && (tgt == TGT_LUT_F);
    assign lut_wr[1]  = cfg_we && (tgt == TGT_LUT_G);
    assign oreg_on[0] = mode_q.reg_f;
    assign oreg_on[1] = mode_q.reg_g;

    for (genvar i = 0; i < NLUT; i++) begin : g_half
        clb_lut #(.K(K)) i_lut (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (lut_wr[i]),
            .wr_data (cfg_data),
            .sel     (lut_sel[i]),
            .dout    (lut_val[i])
        );

        clb_outreg i_oreg (
            .clk     (clk),
            .rst     (rst),
            .ce      (clk_en),
            .use_reg (oreg_on[i]),
            .d       (comb[i]),
            .q       (oq[i]),
            .y       (oy[i])
        );
    end

    clb_merge #(.K(K)) i_merge (
        .merge  (mode_q.merge),
        .in_5   (in_5),
        .in_f   (in_f),
        .in_g   (in_g),
        .lut_f  (lut_val[0]),
        .lut_g  (lut_val[1]),
        .sel_f  (lut_sel[0]),
        .sel_g  (lut_sel[1]),
        .comb_f (comb[0]),
        .comb_g (comb[1])
    );

    assign out_f = oy[0];
    assign out_g = oy[1];

    // flat views for the bound checker
    logic merge_on, reg_f_on, reg_g_on, lut_f_v, lut_g_v, comb_f_v, q_f_v, q_g_v;
    assign merge_on = mode_q.merge;
    assign reg_f_on = mode_q.reg_f;
    assign reg_g_on = mode_q.reg_g;
    assign lut_f_v  = lut_val[0];
    assign lut_g_v  = lut_val[1];
    assign comb_f_v = comb[0];
    assign q_f_v    = oq[0];
    assign q_g_v    = oq[1];

endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk (
    input logic clk,
    input logic rst,
    input logic clk_en,
    input logic in_5,
    input logic merge_on,
    input logic reg_f_on,
    input logic reg_g_on,
    input logic lut_f_v,
    input logic lut_g_v,
    input logic comb_f_v,
    input logic q_f_v,
    input logic q_g_v,
    input logic out_f,
    input logic out_g
);
    assert_split_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (!merge_on && !reg_f_on) |-> (out_f == lut_f_v));

    assert_merge_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (merge_on && in_5 && !reg_f_on) |-> (out_f == lut_g_v));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_f_on && $past(reg_f_on) && $past(clk_en) && !$past(rst))
            |-> (out_f == $past(comb_f_v)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_g_on && $past(reg_g_on) && !$past(clk_en) && !$past(rst))
            |-> (out_g == $past(out_g)));

    assert_reset_clear_R7: assert property (@(posedge clk)
        $past(rst) |-> (!q_f_v && !q_g_v && !merge_on && !reg_f_on && !reg_g_on));

endmodule

bind clb_cell clb_cell_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .in_5     (in_5),
    .merge_on (merge_on),
    .reg_f_on (reg_f_on),
    .reg_g_on (reg_g_on),
    .lut_f_v  (lut_f_v),
    .lut_g_v  (lut_g_v),
    .comb_f_v (comb_f_v),
    .q_f_v    (q_f_v),
    .q_g_v    (q_g_v),
    .out_f    (out_f),
    .out_g    (out_g)
);

// File: tb/test_clb_cell.sv
`timescale 1ns/1ps
module test_clb_cell;
    localparam int K = 4;
    localparam int TBL = 1 << K;

    logic clk = 1'b0;
    logic rst, clk_en, cfg_we, in_5, out_f, out_g;
    logic [1:0] cfg_tgt;
    logic [TBL-1:0] cfg_data;
    logic [K-1:0] in_f, in_g;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    clb_cell #(.K(K)) i_clb_cell (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cfg_we(cfg_we),
        .cfg_tgt(cfg_tgt), .cfg_data(cfg_data), .in_f(in_f),
        .in_g(in_g), .in_5(in_5), .out_f(out_f), .out_g(out_g)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (in_f=%h in_g=%h in_5=%b)",
                     tag, act, exp, in_f, in_g, in_5);
        end
    endtask

    task automatic write_cfg(input logic [1:0] tgt, input logic [TBL-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tgt = tgt; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_data = '0;
    endtask

    task automatic drive(input logic [K-1:0] f, input logic [K-1:0] g, input logic s);
        @(negedge clk);
        in_f = f; in_g = g; in_5 = s;
        #1;
    endtask

    initial begin
        logic [TBL-1:0] tf, tg, eq_t, gt_t, maj_lo, maj_hi;
        rst = 1'b1; clk_en = 1'b0; cfg_we = 1'b0; cfg_tgt = 2'd3;
        cfg_data = '0; in_f = '0; in_g = '0; in_5 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: tables and mode zero
        drive(4'hF, 4'h5, 1'b1);
        check("R7 reset out_f", out_f, 1'b0);
        check("R7 reset out_g", out_g, 1'b0);

        // R1/R2 split-mode exhaustive sweep
        tf = 16'hB4E1; tg = 16'h6A3C;
        write_cfg(2'd0, tf);
        write_cfg(2'd1, tg);
        for (int a = 0; a < TBL; a++) begin
            for (int b = 0; b < TBL; b++) begin
                drive(K'(a), K'(b), 1'(a));
                check("R1 split out_f", out_f, tf[a]);
                check("R1 split out_g", out_g, tg[b]);
            end
        end

        // R11 write strobe low: nothing changes
        @(negedge clk);
        cfg_we = 1'b0; cfg_tgt = 2'd0; cfg_data = 16'hFFFF;
        @(negedge clk);
        cfg_tgt = 2'd2; cfg_data = 16'h0007;
        @(negedge clk);
        for (int a = 0; a < TBL; a++) begin
            drive(K'(a), K'(a), 1'b1);
            check("R11 ignored out_f", out_f, tf[a]);
            check("R11 ignored out_g", out_g, tg[a]);
        end
        // R2 target 3 writes nothing
        write_cfg(2'd3, 16'h0000);
        drive(4'h0, 4'h2, 1'b0);
        check("R2 none target out_f", out_f, tf[0]);
        check("R2 none target out_g", out_g, tg[2]);

        // R3/R4 merged mode sweep, in_g must not matter
        write_cfg(2'd2, 16'h0001);
        for (int a = 0; a < 2*TBL; a++) begin
            drive(K'(a), K'(~a), 1'(a >> K));
            check("R3 merged out_f", out_f, (a >> K) ? tg[a%TBL] : tf[a%TBL]);
            check("R4 merged out_g", out_g, tg[a%TBL]);
        end

        // R9 comparator in split mode
        for (int i = 0; i < TBL; i++) begin
            eq_t[i] = ((i >> 2) == (i & 3));
            gt_t[i] = ((i >> 2) >  (i & 3));
        end
        write_cfg(2'd0, eq_t);
        write_cfg(2'd1, gt_t);
        write_cfg(2'd2, 16'h0000);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                drive(K'(a*4+b), K'(a*4+b), 1'b0);
                check("R9 comparator eq", out_f, a == b);
                check("R9 comparator gt", out_g, a > b);
            end
        end

        // R10 majority of five in merged mode
        for (int i = 0; i < TBL; i++) begin
            maj_lo[i] = ($countones(i) >= 3);
            maj_hi[i] = ($countones(i) + 1 >= 3);
        end
        write_cfg(2'd0, maj_lo);
        write_cfg(2'd1, maj_hi);
        write_cfg(2'd2, 16'h0001);
        for (int a = 0; a < 2*TBL; a++) begin
            drive(K'(a), 4'h0, 1'(a >> K));
            check("R10 majority", out_f, $countones(a) >= 3);
        end

        // R5/R6/R8: out_f registered, out_g combinational, split mode
        write_cfg(2'd0, tf);
        write_cfg(2'd1, tg);
        write_cfg(2'd2, 16'h0002);
        clk_en = 1'b1;
        for (int a = 0; a < TBL; a++) begin
            drive(K'(a), K'(a), 1'b0);
            check("R8 bypass out_g same cycle", out_g, tg[a]);
            @(negedge clk);
            check("R5 captured out_f", out_f, tf[a]);
        end
        // hold with clk_en low
        drive(4'h3, 4'h3, 1'b0);
        @(negedge clk);
        check("R5 captured before hold", out_f, tf[3]);
        clk_en = 1'b0;
        for (int a = 0; a < TBL; a++) begin
            drive(K'(a), K'(a), 1'b0);
            @(negedge clk);
            check("R6 hold out_f", out_f, tf[3]);
        end
        // registered out_g
        write_cfg(2'd2, 16'h0004);
        clk_en = 1'b1;
        drive(4'h6, 4'h9, 1'b0);
        check("R8 bypass out_f", out_f, tf[6]);
        @(negedge clk);
        check("R5 captured out_g", out_g, tg[9]);

        // R7 reset clears everything
        write_cfg(2'd2, 16'h0006);
        in_f = 4'h0; in_g = 4'h0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < TBL; a++) begin
            drive(K'(a), K'(a), 1'b1);
            check("R7 cleared out_f", out_f, 1'b0);
            check("R7 cleared out_g", out_g, 1'b0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule